// File: doc/BRIEF.md
# CAN Standby Wake-up Pattern Detector

This block serves one CAN channel while that channel sits in standby. It samples a single bus-dominant bit, which comes from a low-power receiver, once per clock. It waits for a filtered three-phase pattern on that bit: a dominant phase, then a recessive phase, then a second dominant phase. Each phase must last longer than its own filter time, and the whole pattern must fit inside a fixed window. A bus that stays dominant therefore runs out the window without ever completing the pattern, and it can never wake the system.

Before a wake-up, the receive-data output stays high. Once the pattern completes, the wake flag rises and stays set for as long as standby holds. From then on, the receive-data output follows the bus level (low for dominant, high for recessive) after a fixed, slower delay.

Dropping the standby flag returns the detector to idle, clears the wake flag and stops the toggling report. All times are parameters counted in clock cycles.

Top module: `wake_pattern_det`

## Requirements
- R1: After reset, `wake` is 0, `rxd` is 1 and the detector is idle.
- R2: The first phase needs more than FILT1_CYC consecutive dominant samples (`busDom`=1). A first phase of FILT1_CYC samples or fewer that is followed by a recessive sample sends the detector back to idle without progress.
- R3: The second phase needs more than FILT2_CYC consecutive recessive samples. A dominant sample that arrives earlier sends the detector back to idle.
- R4: The third phase completes on its (FILT2_CYC+1)-th consecutive dominant sample, and `wake` is 1 right after that clock edge. A third phase of only FILT2_CYC samples that is followed by a recessive sample gives no wake-up.
- R5: The window opens on the first dominant sample seen while idle. The pattern wakes only if its completing sample is among the first WINDOW_CYC samples of the window. If it is not, the window expires and no wake-up is reported.
- R6: After the window expires, the detector re-arms only after it sees a recessive sample. A bus held dominant for any length of time never sets `wake`.
- R7: While `wake` is 0, `rxd` is 1 whatever the bus level.
- R8: While `wake` is 1, `rxd` equals the inverse of the `busDom` value sampled TGL_DLY_CYC clock edges earlier.
- R9: Once set, `wake` stays 1 for as long as `standby` stays 1, whatever the bus does.
- R10: When `standby` is 0 at a clock edge, `wake` is 0 and `rxd` is 1 after that edge, and no pattern is detected while `standby` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low asynchronous reset |
| standby | input | 1 | 1 while the channel is in standby; 0 clears the detector |
| busDom | input | 1 | Sampled bus level, 1 = dominant, 0 = recessive |
| rxd | output | 1 | Receive-data report: held high until wake-up, then the delayed inverse of the bus |
| wake | output | 1 | Set when the wake-up pattern has been recognised |

## Verification
`wake` is registered. It rises on the very clock edge that samples the completing dominant bit of phase three, so the bench checks it half a cycle after that edge. The bench also checks it one sample earlier, where it must still be 0. `rxd` lags the bus by exactly TGL_DLY_CYC edges, so after a bus change the bench checks `rxd` after TGL_DLY_CYC-1 edges, expecting the old level, and after TGL_DLY_CYC edges, expecting the new one. The bench changes the inputs only on falling edges and checks the outputs only there, and it counts every phase and window length in samples. This places each boundary case (a phase exactly at its filter length, a pattern ending on the last or the first-too-late sample of the window) on a known edge.

// File: rtl/wake_pkg.sv
`timescale 1ns/1ps
package wake_pkg;

  typedef enum logic [2:0] {
    W_IDLE  = 3'd0,
    W_DOM1  = 3'd1,
    W_REC2  = 3'd2,
    W_DOM3  = 3'd3,
    W_HOLD  = 3'd4,
    W_AWAKE = 3'd5
  } wakeState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic phaseRestart;
    logic winStart;
    logic toggleEn;
  } wakeCtl_t;

  // comparisons reported by the datapath
  typedef struct packed {
    logic dom1Long;
    logic rec2Long;
    logic dom3Done;
    logic winExpired;
  } wakeSts_t;

endpackage

// File: rtl/wake_datapath.sv
`timescale 1ns/1ps
module wake_datapath
  import wake_pkg::*;
#(
  parameter int FILT1_CYC   = 6,
  parameter int FILT2_CYC   = 3,
  parameter int WINDOW_CYC  = 40,
  parameter int TGL_DLY_CYC = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     busDom,
  input  wakeCtl_t ctl,
  output wakeSts_t sts,
  output logic     rxdOut
);

  localparam int PH_MAX = ((FILT1_CYC > FILT2_CYC) ? FILT1_CYC : FILT2_CYC) + 1;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int WIN_W  = $clog2(WINDOW_CYC + 1);
  localparam logic [PH_W-1:0]  PhSat  = PH_W'(PH_MAX);
  localparam logic [PH_W-1:0]  Filt1  = PH_W'(FILT1_CYC);
  localparam logic [PH_W-1:0]  Filt2  = PH_W'(FILT2_CYC);
  localparam logic [WIN_W-1:0] WinLim = WIN_W'(WINDOW_CYC);

  logic [PH_W-1:0]        phaseCnt;
  logic [WIN_W-1:0]       winCnt;
  logic [TGL_DLY_CYC-1:0] busDly;

  // samples held in the current phase, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 phaseCnt <= '0;
    else if (ctl.phaseRestart) phaseCnt <= PH_W'(1);
    else if (phaseCnt != PhSat) phaseCnt <= phaseCnt + 1'b1;
  end

  // samples since the window opened, saturating at the limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  winCnt <= '0;
    else if (ctl.winStart)      winCnt <= WIN_W'(1);
    else if (winCnt != WinLim)  winCnt <= winCnt + 1'b1;
  end

  // bus history for the slow toggling report
  generate
    if (TGL_DLY_CYC == 1) begin : g_dly1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) busDly <= '0;
        else       busDly <= busDom;
      end
    end else begin : g_dlyN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) busDly <= '0;
        else       busDly <= {busDly[TGL_DLY_CYC-2:0], busDom};
      end
    end
  endgenerate

  always_comb begin
    sts.dom1Long   = (phaseCnt > Filt1);
    sts.rec2Long   = (phaseCnt > Filt2);
    sts.dom3Done   = (phaseCnt >= Filt2);
    sts.winExpired = (winCnt >= WinLim);
  end

  assign rxdOut = ctl.toggleEn ? ~busDly[TGL_DLY_CYC-1] : 1'b1;

  // R7: the report stays high whenever toggling is off
  p_rxd_high_when_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.toggleEn |-> rxdOut);

  // R5: the window counter never runs past its limit
  p_win_bounded_r5: assert property (@(posedge clk) disable iff (!rstN)
    winCnt <= WinLim);

endmodule

// File: rtl/wake_ctrl.sv
`timescale 1ns/1ps
module wake_ctrl
  import wake_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     standby,
  input  logic     busDom,
  input  wakeSts_t sts,
  output wakeCtl_t ctl,
  output logic     wakeOut
);

  wakeState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= W_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState        = state;
    ctl.phaseRestart = 1'b0;
    ctl.winStart     = 1'b0;
    ctl.toggleEn     = (state == W_AWAKE);
    if (!standby) begin
      nextState = W_IDLE;
    end else begin
      unique case (state)
        W_IDLE: if (busDom) begin
          nextState        = W_DOM1;
          ctl.phaseRestart = 1'b1;
          ctl.winStart     = 1'b1;
        end
        W_DOM1: begin
          if (sts.winExpired)  nextState = W_HOLD;
          else if (!busDom) begin
            if (sts.dom1Long) begin
              nextState        = W_REC2;
              ctl.phaseRestart = 1'b1;
            end else nextState = W_IDLE;
          end
        end
        W_REC2: begin
          if (sts.winExpired) nextState = W_HOLD;
          else if (busDom) begin
            if (sts.rec2Long) begin
              nextState        = W_DOM3;
              ctl.phaseRestart = 1'b1;
            end else nextState = W_IDLE;
          end
        end
        W_DOM3: begin
          if (sts.winExpired)    nextState = W_HOLD;
          else if (!busDom)      nextState = W_IDLE;
          else if (sts.dom3Done) nextState = W_AWAKE;
        end
        W_HOLD:  if (!busDom) nextState = W_IDLE;
        W_AWAKE: nextState = W_AWAKE;
        default: nextState = W_IDLE;
      endcase
    end
  end

  assign wakeOut = (state == W_AWAKE);

  // R10: standby low at an edge leaves no wake afterwards
  p_clear_on_exit_r10: assert property (@(posedge clk) disable iff (!rstN)
    !standby |=> !wakeOut);

  // R9: wake holds while standby stays set
  p_wake_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wakeOut && standby) |=> wakeOut);

  // R4: a wake-up only follows a dominant sample in the third phase
  p_wake_from_dom3_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == W_DOM3 && standby && busDom && !sts.winExpired && sts.dom3Done) |=> wakeOut);

  // R5: an expired window never leads straight to a wake-up
  p_no_wake_after_expiry_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sts.winExpired && (state == W_DOM1 || state == W_REC2 || state == W_DOM3)) |=> !wakeOut);

  // R6: leaving the expired state only happens on a recessive sample
  p_rearm_recessive_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == W_HOLD && busDom && standby) |=> state == W_HOLD);

endmodule

// File: rtl/wake_pattern_det.sv
`timescale 1ns/1ps
module wake_pattern_det
  import wake_pkg::*;
#(
  parameter int FILT1_CYC   = 6,
  parameter int FILT2_CYC   = 3,
  parameter int WINDOW_CYC  = 40,
  parameter int TGL_DLY_CYC = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic standby,
  input  logic busDom,
  output logic rxd,
  output logic wake
);

  wakeCtl_t ctl;
  wakeSts_t sts;

  wake_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .standby (standby),
    .busDom  (busDom),
    .sts     (sts),
    .ctl     (ctl),
    .wakeOut (wake)
  );

  wake_datapath #(
    .FILT1_CYC   (FILT1_CYC),
    .FILT2_CYC   (FILT2_CYC),
    .WINDOW_CYC  (WINDOW_CYC),
    .TGL_DLY_CYC (TGL_DLY_CYC)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .busDom (busDom),
    .ctl    (ctl),
    .sts    (sts),
    .rxdOut (rxd)
  );

endmodule

// File: tb/wake_pattern_det_bench.sv
`timescale 1ns/1ps
module wake_pattern_det_bench;

  localparam int F1  = 6;
  localparam int F2  = 3;
  localparam int WIN = 40;
  localparam int TGL = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic standby = 1'b1;
  logic busDom = 1'b0;
  logic rxd, wake;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  wake_pattern_det #(
    .FILT1_CYC(F1), .FILT2_CYC(F2), .WINDOW_CYC(WIN), .TGL_DLY_CYC(TGL)
  ) u_wake_pattern_det (
    .clk(clk), .rstN(rstN), .standby(standby), .busDom(busDom),
    .rxd(rxd), .wake(wake)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // drive a level for n samples; returns at a falling edge
  task automatic hold(input logic lvl, input int n);
    busDom = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    hold(1'b0, WIN + 5);
  endtask

  task automatic t_reset();
    check("R1", "wake after reset", wake, 1'b0);
    check("R1", "rxd after reset", rxd, 1'b1);
  endtask

  task automatic t_short_phase1();
    settle();
    hold(1'b1, F1);            // only F1 samples: too short
    hold(1'b0, F2 + 1);
    hold(1'b1, F2 + 1);
    check("R2", "wake after short phase one", wake, 1'b0);
    check("R7", "rxd while bus dominant before wake", rxd, 1'b1);
  endtask

  task automatic t_short_phase2();
    settle();
    hold(1'b1, F1 + 1);
    hold(1'b0, F2);            // too short
    hold(1'b1, F2 + 1);
    check("R3", "wake after short phase two", wake, 1'b0);
  endtask

  task automatic t_short_phase3();
    settle();
    hold(1'b1, F1 + 1);
    hold(1'b0, F2 + 1);
    hold(1'b1, F2);
    hold(1'b0, 1);
    hold(1'b1, F2 + 1);        // restarts as phase one only
    check("R4", "wake after short phase three", wake, 1'b0);
  endtask

  task automatic t_wake_and_toggle();
    settle();
    hold(1'b1, F1 + 1);
    hold(1'b0, F2 + 1);
    hold(1'b1, F2);
    check("R4", "wake one sample before phase three ends", wake, 1'b0);
    hold(1'b1, 1);
    check("R4", "wake at end of phase three", wake, 1'b1);
    check("R8", "rxd low for dominant history", rxd, 1'b0);
    hold(1'b0, TGL - 1);
    check("R8", "rxd before delay elapses", rxd, 1'b0);
    hold(1'b0, 1);
    check("R8", "rxd after delay to recessive", rxd, 1'b1);
    hold(1'b1, TGL - 1);
    check("R8", "rxd before delay to dominant", rxd, 1'b1);
    hold(1'b1, 1);
    check("R8", "rxd after delay to dominant", rxd, 1'b0);
    hold(1'b0, 2 * WIN);
    hold(1'b1, 2 * WIN);
    check("R9", "wake held through bus activity", wake, 1'b1);
    standby = 1'b0;
    @(negedge clk);
    check("R10", "wake cleared on leaving standby", wake, 1'b0);
    check("R10", "rxd high on leaving standby", rxd, 1'b1);
    hold(1'b0, F2 + 1);
    hold(1'b1, F1 + 1);
    hold(1'b0, F2 + 1);
    hold(1'b1, F2 + 1);
    check("R10", "no wake outside standby", wake, 1'b0);
    standby = 1'b1;
  endtask

  task automatic t_window_edges();
    // completing sample is sample WIN of the window: accepted
    settle();
    hold(1'b1, WIN - 2 * (F2 + 1));
    hold(1'b0, F2 + 1);
    hold(1'b1, F2 + 1);
    check("R5", "wake on last sample of window", wake, 1'b1);
    standby = 1'b0;
    @(negedge clk);
    standby = 1'b1;
    // one sample later: rejected
    settle();
    hold(1'b1, WIN - 2 * (F2 + 1) + 1);
    hold(1'b0, F2 + 1);
    hold(1'b1, F2 + 1);
    check("R5", "no wake one sample past window", wake, 1'b0);
    hold(1'b1, F2 + 1);
    check("R5", "still no wake after expiry", wake, 1'b0);
  endtask

  task automatic t_stuck_dominant();
    settle();
    hold(1'b1, 20 * WIN);
    check("R6", "no wake on stuck dominant", wake, 1'b0);
    check("R6", "rxd high on stuck dominant", rxd, 1'b1);
    hold(1'b0, F2 + 1);        // re-arms here
    hold(1'b1, F1 + 1);
    hold(1'b0, F2 + 1);
    hold(1'b1, F2 + 1);
    check("R6", "wake after re-arm", wake, 1'b1);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_short_phase1();
    t_short_phase2();
    t_short_phase3();
    t_wake_and_toggle();
    t_window_edges();
    standby = 1'b0;
    @(negedge clk);
    standby = 1'b1;
    t_stuck_dominant();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule